// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait-State Acknowledge

The block decodes bus requests into eight active-low chip selects. Each channel owns a base address, a per-bit address mask, a set of access-type exclusion bits, a write-protect bit and a control word that sets the wait-state count, the acknowledge source, the port width, the byte-enable policy and the burst permission for each direction. A request is compared against every valid channel in one cycle. The lowest-numbered hit is latched, its select is driven, and the transfer stays open until an acknowledge ends it.

Software programs the channels through a small write/read register port. The address is `{channel[2:0], field[1:0]}`. Field 0 is the 16-bit base, field 1 the mask word, field 2 the control word, and field 3 of channel 0 the shared 8-bit upper base. Channels 0 and 1 compare their base against address bits 31:16. Channels 2 to 7 compare bits 31:24 against the shared upper base and bits 23:16 against the low byte of their own base. While a transfer is open, the block also reports the port width, how many port-sized beats the transfer needs, and whether those beats may be burst.

Top module: `cs_decode`

## Requirements
- R1: After reset every base, mask and shared base reads 0 and every control word reads 0. The exception is channel 0's control word, which reads 0x0BF: wait 15, internal acknowledge on, 8-bit port, byte enables on reads. Written fields read back. Mask word bits 15:7 and control bits 31:10 read 0.
- R2: A valid channel hits when every address bit from 31 to 16 equals its effective base bit, or the matching bit of mask[31:16] is 1. The select `cs_n[c]` goes low on the clock edge that accepts the request.
- R3: The request type is encoded 0 user data, 1 user code, 2 supervisor data, 3 supervisor code, 4 CPU space/interrupt acknowledge. Types 0 to 3 are excluded from a channel's hit when mask bit 2, 3, 4 or 5 is set, respectively. Mask bit 6 excludes type 4, but that bit is stored only on channels 0, 1 and 7; on other channels it reads 0 and type 4 can hit. Types 5 to 7 never hit a valid channel.
- R4: When mask bit 1 (write protect) is set, a write never hits that channel. A read to the same range still hits.
- R5: A channel with mask bit 0 (valid) clear never hits. The exception is channel 0: while its valid bit is clear, it hits every request.
- R6: When several channels hit, only the lowest-numbered one is selected, so at most one `cs_n` bit is ever low.
- R7: Control bits 3:0 hold a wait count W, and bit 4 enables the internal acknowledge. With bit 4 set, `ack` is high during the W-th cycle after the accepting edge (counting that first cycle as 0), and the select is released on the following edge.
- R8: With control bit 4 clear, `ack` stays low, and the transfer ends on the first clock edge at which `ext_ack` is high.
- R9: `ack` is a single-cycle pulse. While a transfer is open, new requests are ignored and the select does not change. A request is accepted only in a cycle that starts with no transfer open.
- R10: Control bits 6:5 give the port: 00 32-bit, 01 8-bit, 10 or 11 16-bit. `port_w` reports the log2 of the port width in bytes (0, 1 or 2). The request size is encoded 0 byte, 1 word, 2 longword, 3 16-byte line. `beats` is the size divided by the port width, with a minimum of 1. `burst` is 1 only when the size exceeds the port and the direction's burst enable is set: control bit 8 for reads, bit 9 for writes.
- R11: Control bit 7 sets the byte-enable policy. `be_act` is 1 for a write, and for a read only when bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select {channel, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Transfer size code |
| req_type | input | 3 | Access type code |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| ack | output | 1 | Internal acknowledge pulse |
| port_w | output | 2 | Log2 port width in bytes of open transfer |
| beats | output | 5 | Port-sized beats of open transfer |
| burst | output | 1 | Beats may be bursted |
| be_act | output | 1 | Byte enables driven for this transfer |

## Verification
Two things can land in the same cycle: the acknowledge that closes a transfer, and a request that is already waiting. The bench also writes registers while a transfer is open. To provoke the first case, it holds a request to a different channel across the whole wait-state window of a protected-write transfer. The checks then confirm three things: the open select never moves, exactly one acknowledge pulse appears, and the waiting request is taken only after one idle cycle. A behavioural reference model, run every clock, judges the selects, acknowledge and transfer shape on every cycle.

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter logic [9:0] BOOT_CTL = 10'h0BF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [2:0]  req_type,
  input  logic        ext_ack,
  output logic [7:0]  cs_n,
  output logic        ack,
  output logic [1:0]  port_w,
  output logic [4:0]  beats,
  output logic        burst,
  output logic        be_act
);
  localparam int NCH = 8;

  logic [15:0] base_q [NCH];
  logic [15:0] mhi_q  [NCH];
  logic [6:0]  mlo_q  [NCH];
  logic [9:0]  ctl_q  [NCH];
  logic [7:0]  shb_q;

  logic [2:0] wch;
  logic [1:0] wfld;
  assign wch  = reg_addr[4:2];
  assign wfld = reg_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        base_q[c] <= '0;
        mhi_q[c]  <= '0;
        mlo_q[c]  <= '0;
        ctl_q[c]  <= (c == 0) ? BOOT_CTL : '0;
      end
      shb_q <= '0;
    end else if (reg_we) begin
      case (wfld)
        2'd0: base_q[wch] <= reg_wdata[15:0];
        2'd1: begin
          mhi_q[wch] <= reg_wdata[31:16];
          mlo_q[wch] <= {reg_wdata[6] & (wch == 3'd0 || wch == 3'd1 || wch == 3'd7),
                         reg_wdata[5:0]};
        end
        2'd2: ctl_q[wch] <= reg_wdata[9:0];
        default: if (wch == 3'd0) shb_q <= reg_wdata[7:0];
      endcase
    end
  end

  always_comb begin
    case (wfld)
      2'd0:    reg_rdata = {16'h0, base_q[wch]};
      2'd1:    reg_rdata = {mhi_q[wch], 9'h0, mlo_q[wch]};
      2'd2:    reg_rdata = {22'h0, ctl_q[wch]};
      default: reg_rdata = (wch == 3'd0) ? {24'h0, shb_q} : 32'h0;
    endcase
  end

  logic [NCH-1:0] hit;
  logic [15:0]    eff_base;
  logic           type_rej;

  always_comb begin
    hit      = '0;
    eff_base = '0;
    type_rej = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      eff_base = (c < 2) ? base_q[c] : {shb_q, base_q[c][7:0]};
      case (req_type)
        3'd0:    type_rej = mlo_q[c][2];
        3'd1:    type_rej = mlo_q[c][3];
        3'd2:    type_rej = mlo_q[c][4];
        3'd3:    type_rej = mlo_q[c][5];
        3'd4:    type_rej = mlo_q[c][6];
        default: type_rej = 1'b1;
      endcase
      hit[c] = (c == 0 && !mlo_q[0][0]) ||
               (mlo_q[c][0] && (((req_addr[31:16] ^ eff_base) & ~mhi_q[c]) == 16'h0) &&
                !type_rej && !(req_write && mlo_q[c][1]));
    end
  end

  logic [2:0] win;
  always_comb begin
    win = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (hit[c]) win = c[2:0];
  end

  logic [9:0] wctl;
  logic [1:0] pw_l;
  logic [2:0] sz_l;
  logic       big;
  assign wctl = ctl_q[win];
  assign pw_l = (wctl[6:5] == 2'b00) ? 2'd2 : (wctl[6:5] == 2'b01) ? 2'd0 : 2'd1;
  assign sz_l = (req_size == 2'd3) ? 3'd4 : {1'b0, req_size};
  assign big  = sz_l > {1'b0, pw_l};

  logic       active_q, la_q;
  logic [3:0] cnt_q;
  logic       done;

  assign ack  = active_q && la_q && (cnt_q == 4'd0);
  assign done = ack || (active_q && !la_q && ext_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      la_q     <= 1'b0;
      cnt_q    <= '0;
      cs_n     <= '1;
      port_w   <= '0;
      beats    <= '0;
      burst    <= 1'b0;
      be_act   <= 1'b0;
    end else if (!active_q) begin
      if (req_valid && |hit) begin
        active_q <= 1'b1;
        la_q     <= wctl[4];
        cnt_q    <= wctl[3:0];
        cs_n     <= ~(8'd1 << win);
        port_w   <= pw_l;
        beats    <= big ? (5'd1 << (sz_l - {1'b0, pw_l})) : 5'd1;
        burst    <= big && (req_write ? wctl[9] : wctl[8]);
        be_act   <= req_write || wctl[7];
      end
    end else if (done) begin
      active_q <= 1'b0;
      cs_n     <= '1;
      port_w   <= '0;
      beats    <= '0;
      burst    <= 1'b0;
      be_act   <= 1'b0;
    end else if (cnt_q != 4'd0) begin
      cnt_q <= cnt_q - 4'd1;
    end
  end

  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (&cs_n));
  assert_wait_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && la_q && cnt_q != 4'd0) |=> (cnt_q == $past(cnt_q) - 4'd1));
  assert_select_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !done) |=> ($stable(cs_n) && $stable(beats)));
endmodule

// File: tb/sim_cs_decode.sv
module sim_cs_decode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0; logic [4:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0; logic [31:0] req_addr = 0; logic req_write = 0;
  logic [1:0] req_size = 0; logic [2:0] req_type = 0; logic ext_ack = 0;
  logic [7:0] cs_n; logic ack; logic [1:0] port_w; logic [4:0] beats; logic burst, be_act;

  always #10 clk = ~clk;

  cs_decode u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_type(req_type), .ext_ack(ext_ack), .cs_n(cs_n), .ack(ack),
    .port_w(port_w), .beats(beats), .burst(burst), .be_act(be_act));

  int nchk = 0, nerr = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_base [8]; logic [15:0] m_mhi [8]; logic [6:0] m_mlo [8];
  logic [9:0] m_ctl [8]; logic [7:0] m_shb;
  bit m_act, m_la; int m_cnt; logic [7:0] m_cs; int m_pw, m_beats; bit m_burst, m_be;

  function automatic bit mhit(input int c);
    logic [15:0] eb; bit rej;
    if (c == 0 && !m_mlo[0][0]) return 1;
    if (!m_mlo[c][0]) return 0;
    eb = (c < 2) ? m_base[c] : {m_shb, m_base[c][7:0]};
    for (int b = 0; b < 16; b++)
      if (!m_mhi[c][b] && req_addr[16+b] != eb[b]) return 0;
    if (req_type < 4) rej = m_mlo[c][req_type + 2];
    else if (req_type == 4) rej = (c == 0 || c == 1 || c == 7) ? m_mlo[c][6] : 0;
    else rej = 1;
    if (rej) return 0;
    if (req_write && m_mlo[c][1]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin
        m_base[c] = 0; m_mhi[c] = 0; m_mlo[c] = 0; m_ctl[c] = 0;
      end
      m_ctl[0] = 10'h0BF; m_shb = 0;
      m_act = 0; m_la = 0; m_cnt = 0; m_cs = 8'hFF;
      m_pw = 0; m_beats = 0; m_burst = 0; m_be = 0;
    end else begin
      if (m_act) begin
        if ((m_la && m_cnt == 0) || (!m_la && ext_ack)) begin
          m_act = 0; m_cs = 8'hFF; m_pw = 0; m_beats = 0; m_burst = 0; m_be = 0;
        end else if (m_cnt > 0) m_cnt--;
      end else if (req_valid) begin
        int w; int pb, sb;
        w = -1;
        for (int c = 7; c >= 0; c--) if (mhit(c)) w = c;
        if (w >= 0) begin
          m_act = 1; m_la = m_ctl[w][4]; m_cnt = m_ctl[w][3:0];
          m_cs = 8'hFF; m_cs[w] = 0;
          pb = (m_ctl[w][6:5] == 0) ? 4 : (m_ctl[w][6:5] == 1) ? 1 : 2;
          sb = (req_size == 3) ? 16 : (1 << req_size);
          m_pw = (pb == 1) ? 0 : (pb == 2) ? 1 : 2;
          m_beats = (sb > pb) ? sb / pb : 1;
          m_burst = (sb > pb) && (req_write ? m_ctl[w][9] : m_ctl[w][8]);
          m_be = req_write || m_ctl[w][7];
        end
      end
      if (reg_we) begin
        case (reg_addr[1:0])
          0: m_base[reg_addr[4:2]] = reg_wdata[15:0];
          1: begin m_mhi[reg_addr[4:2]] = reg_wdata[31:16]; m_mlo[reg_addr[4:2]] = reg_wdata[6:0]; end
          2: m_ctl[reg_addr[4:2]] = reg_wdata[9:0];
          default: if (reg_addr[4:2] == 0) m_shb = reg_wdata[7:0];
        endcase
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(cs_n, m_cs, "R2 R6 cs_n vs model");
    chk(ack, (m_act && m_la && m_cnt == 0), "R7 ack vs model");
    chk(port_w, m_pw, "R10 port_w vs model");
    chk(beats, m_beats, "R10 beats vs model");
    chk(burst, m_burst, "R10 burst vs model");
    chk(be_act, m_be, "R11 be_act vs model");
  end

  task automatic wr(input int ch, input int fld, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = {ch[2:0], fld[1:0]}; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int ch, input int fld, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = {ch[2:0], fld[1:0]}; #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic run(input logic [31:0] a, input bit w, input int sz, input int ty,
                     input logic [7:0] exp_cs, input int exp_beats, input bit exp_be,
                     input int exp_dly, input string tag);
    int n;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_size = sz[1:0]; req_type = ty[2:0];
    @(negedge clk);
    req_valid = 0;
    chk(cs_n, exp_cs, {tag, " select"});
    if (exp_cs == 8'hFF || exp_dly < 0) return;
    chk(beats, exp_beats, {tag, " beats"});
    chk(be_act, exp_be, {tag, " byte enables"});
    n = 0;
    while (!ack && n < 40) begin @(negedge clk); n++; end
    chk(n, exp_dly, {tag, " wait cycles"});
    @(negedge clk);
    chk(cs_n, 8'hFF, {tag, " release"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    chk(cs_n, 8'hFF, "R1 reset selects");
    chk(ack, 0, "R1 reset ack");
    rd(0, 2, 32'h0BF, "R1 ch0 control reset");
    rd(1, 2, 32'h0, "R1 ch1 control reset");
    rd(3, 1, 32'h0, "R1 ch3 mask reset");
    // boot select: 8-bit port, 15 waits, byte enables on reads
    run(32'h1234_5678, 0, 2, 0, 8'hFE, 4, 1, 15, "R5 boot select");
    // programming
    wr(0, 0, 32'h0000); wr(0, 1, 32'h00FF_0001); wr(0, 2, 32'h012); wr(0, 3, 32'h20);
    wr(1, 0, 32'h0100); wr(1, 1, 32'h00FF_0001); wr(1, 2, 32'h150);
    wr(2, 0, 32'h0040); wr(2, 1, 32'h000F_0003); wr(2, 2, 32'h0A0);
    wr(3, 0, 32'h0040); wr(3, 1, 32'h000F_0001); wr(3, 2, 32'h015);
    wr(4, 0, 32'h0080); wr(4, 1, 32'h0000_0045); wr(4, 2, 32'h010);
    wr(7, 0, 32'h0090); wr(7, 1, 32'h0000_0041); wr(7, 2, 32'h011);
    rd(0, 1, 32'h00FF_0001, "R1 ch0 mask readback");
    rd(0, 3, 32'h20, "R1 shared base readback");
    rd(1, 3, 32'h0, "R1 field 3 of ch1 reads 0");
    rd(4, 1, 32'h0000_0005, "R3 ch4 drops type-4 mask bit");
    rd(7, 1, 32'h0000_0041, "R3 ch7 keeps type-4 mask bit");
    run(32'h0012_0000, 0, 2, 2, 8'hFE, 1, 0, 2, "R2 ch0 masked range");
    run(32'h0100_0000, 0, 2, 0, 8'hFD, 2, 0, 0, "R10 ch1 long read burst");
    chk(burst, 0, "R10 burst cleared after release");
    run(32'h0133_0000, 1, 2, 0, 8'hFD, 2, 1, 0, "R10 ch1 long write split");
    run(32'h0100_0000, 0, 3, 1, 8'hFD, 8, 0, 0, "R10 ch1 line read");
    run(32'h0200_0000, 0, 0, 0, 8'hFF, 0, 0, 0, "R2 no channel in range");
    // overlap ch2/ch3, external acknowledge
    run(32'h2045_0000, 0, 0, 0, 8'hFB, 1, 1, -1, "R6 lowest channel wins");
    for (int i = 0; i < 4; i++) begin @(negedge clk); chk(ack, 0, "R8 no internal ack"); end
    chk(cs_n, 8'hFB, "R8 select held until external ack");
    ext_ack = 1; @(negedge clk); ext_ack = 0;
    chk(cs_n, 8'hFF, "R8 external ack ends transfer");
    run(32'h2045_0000, 1, 2, 0, 8'hF7, 1, 1, 5, "R4 protected write falls to ch3");
    run(32'h2080_0000, 0, 2, 0, 8'hFF, 0, 0, 0, "R3 user data excluded");
    run(32'h2080_0000, 0, 2, 1, 8'hEF, 1, 0, 0, "R3 user code hits ch4");
    run(32'h2080_0000, 0, 2, 4, 8'hEF, 1, 0, 0, "R3 cpu space hits ch4");
    run(32'h2090_0000, 0, 2, 4, 8'hFF, 0, 0, 0, "R3 cpu space masked on ch7");
    run(32'h2090_0000, 0, 2, 3, 8'h7F, 1, 0, 1, "R3 supervisor code ch7");
    run(32'h2090_0000, 0, 2, 6, 8'hFF, 0, 0, 0, "R3 reserved type never hits");
    run(32'h0012_0000, 1, 0, 0, 8'hFE, 1, 1, 2, "R11 write drives byte enables");
    wr(4, 1, 32'h0);
    run(32'h2080_0000, 0, 2, 1, 8'hFF, 0, 0, 0, "R5 invalid channel silent");
    // busy: a waiting request to ch1 held across a ch3 transfer
    begin
      int acks;
      acks = 0;
      @(negedge clk);
      req_valid = 1; req_addr = 32'h2045_0000; req_write = 1; req_size = 2; req_type = 0;
      @(negedge clk);
      req_addr = 32'h0100_0000; req_write = 0;
      reg_we = 1; reg_addr = {3'd3, 2'd2}; reg_wdata = 32'h010;
      for (int i = 0; i < 6; i++) begin
        chk(cs_n, 8'hF7, "R9 select held while busy");
        if (ack) acks++;
        @(negedge clk); reg_we = 0;
      end
      chk(acks, 1, "R9 single ack pulse");
      chk(cs_n, 8'hFF, "R9 idle cycle before next request");
      @(negedge clk);
      chk(cs_n, 8'hFD, "R9 waiting request accepted");
      req_valid = 0;
      @(negedge clk);
      run(32'h2045_0000, 1, 2, 0, 8'hF7, 1, 1, 0, "R7 new wait count applies");
    end
    repeat (2) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R9 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule